// File: doc/BRIEF.md
# Trigger Rate Limiter with Front-End Buffer Emulation

This block sits in the central timing controller and runs on the bunch-crossing clock (40 MHz, 25 ns period). Each cycle it may receive a raw first-level trigger accept. It decides whether to pass that accept on to the front-end electronics. It keeps a cycle-accurate model of the front-end derandomizing buffer. The model fills by one entry for every accept that is passed on. It empties by one entry each time a fixed per-event readout time runs out. An accept that would push the model beyond its capacity is turned into a reject.

Two further conditions can hold accepts back. The first is a throttle level sent by the downstream readout boards. This level is asynchronous to the block's clock, so it is synchronised with two flops before use. The second is a pool of readiness credits. Each request message from a farm node adds one credit. The pool is drawn down by one credit for every N accepts that are passed on, where N is the packing factor. While the pool is empty, accepts are held back.

Every rejected accept is charged to exactly one cause. The block keeps one saturating counter per cause.

Top module: `trl_rate_limiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `accept_o` is 0 and all three reject counters are 0. Reset also empties the buffer model and the credit pool, clears the packing count and clears both synchroniser flops.
- R2: `accept_o` is a registered output. It is 1 in the cycle after `l0_accept_i` was sampled high with no veto active. It is never 1 unless `l0_accept_i` was high on the edge before.
- R3: Each forwarded accept adds one entry to the buffer model, which holds up to `BUF_DEPTH` entries. An accept that arrives while the model holds `BUF_DEPTH` entries is rejected. This also applies when a drain falls on that same edge.
- R4: While the buffer model is not empty, an internal count advances once per cycle. When the model has been non-empty for `DRAIN_CYCLES` cycles, one entry is removed and the count starts again from zero. While the model is empty, the count stays at zero.
- R5: `throttle_async_i` reaches the veto logic through two flops. A level that is present at clock edge k vetoes the accepts sampled at edge k+2 and at every later edge until it has been low for two edges.
- R6: Each cycle with `credit_req_i` high adds one credit. The pool saturates at 2^`CREDIT_W`-1, and a new credit can be used from the next cycle. While the pool is empty, accepts are rejected.
- R7: One credit is removed on every N-th forwarded accept, where N is `pack_factor_i` and a value of 0 counts as 1. A removal and a request on the same edge cancel each other.
- R8: A rejected accept has exactly one cause, chosen in priority order: throttle first, then an empty credit pool, then a full buffer model. Only the counter for that cause advances: `rej_thr_cnt_o`, `rej_cred_cnt_o` or `rej_buf_cnt_o`.
- R9: Each reject counter stops at all ones (2^`CNT_W`-1) and holds that value until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l0_accept_i | input | 1 | Raw first-level accept for this crossing |
| throttle_async_i | input | 1 | Asynchronous hold-off level from the readout boards |
| credit_req_i | input | 1 | One farm-node readiness request this cycle |
| pack_factor_i | input | PACK_W | Number of forwarded accepts per credit (0 counts as 1) |
| accept_o | output | 1 | Filtered accept towards the front-end electronics |
| rej_buf_cnt_o | output | CNT_W | Rejects caused by the buffer model being full |
| rej_thr_cnt_o | output | CNT_W | Rejects caused by the throttle |
| rej_cred_cnt_o | output | CNT_W | Rejects caused by an empty credit pool |

## Verification
The bench builds the block with `BUF_DEPTH`=4, `DRAIN_CYCLES`=6, `CREDIT_W`=3, `PACK_W`=3 and `CNT_W`=4. With these sizes the buffer model fills after four back-to-back accepts and empties within a few dozen cycles. The credit pool saturates after seven requests, and every reject counter reaches its ceiling well inside the run. This lets the full-buffer edge, the drain boundary, credit saturation and exhaustion, packing factors from 0 to 4, and counter saturation all occur many times. The same parameter values also keep the throttle's two-edge latency and the veto priority under repeated test.

// File: rtl/trl_pkg.sv
// Package: shared types for the trigger rate limiter.
// Assumes: nothing beyond IEEE 1800-2017.
package trl_pkg;

    // Cause of a veto; VETO_NONE means the accept may pass.
    typedef enum logic [1:0] {
        VETO_NONE = 2'd0,
        VETO_THR  = 2'd1,
        VETO_CRED = 2'd2,
        VETO_BUF  = 2'd3
    } veto_e;

    // Index of each cause in the reject counter array.
    localparam int unsigned IDX_BUF  = 0;
    localparam int unsigned IDX_THR  = 1;
    localparam int unsigned IDX_CRED = 2;
    localparam int unsigned N_CAUSES = 3;

endpackage

// File: rtl/trl_sync2.sv
// Module: two-flop synchroniser for a single level.
// Does: brings an asynchronous level into the clock domain.
// Assumes: the input is a slow level (held for several cycles);
// the output reads 0 during reset.
module trl_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic meta_q;
    logic stable_q;

    // Shift the level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else begin
            meta_q   <= d_i;
            stable_q <= meta_q;
        end
    end

    assign q_o = stable_q;

endmodule

// File: rtl/trl_buf_model.sv
// Module: synchronous model of the remote front-end derandomizer.
// Does: counts how many events are queued at the front end and
// removes one every DRAIN cycles while it is not empty.
// Assumes: push_i is only raised when full_o is low; a drain on the
// same edge as a push leaves the occupancy unchanged.
module trl_buf_model #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DRAIN = 36,
    localparam int unsigned OCC_W = $clog2(DEPTH + 1),
    localparam int unsigned DRN_W = (DRAIN > 1) ? $clog2(DRAIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    output logic             full_o,
    output logic [OCC_W-1:0] occ_o
);

    localparam logic [OCC_W-1:0] OCC_MAX  = OCC_W'(DEPTH);
    localparam logic [DRN_W-1:0] DRN_LAST = DRN_W'(DRAIN - 1);

    logic [OCC_W-1:0] occ_q;
    logic [DRN_W-1:0] drn_q;
    logic             busy;
    logic             drain;

    assign busy  = (occ_q != '0);
    assign drain = busy && (drn_q == DRN_LAST);

    // Drain timer: runs only while events are queued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drn_q <= '0;
        end else if (!busy || drain) begin
            drn_q <= '0;
        end else begin
            drn_q <= drn_q + 1'b1;
        end
    end

    // Occupancy: one up per push, one down per drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            case ({push_i, drain})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign full_o = (occ_q == OCC_MAX);
    assign occ_o  = occ_q;

endmodule

// File: rtl/trl_credit_pool.sv
// Module: pool of farm readiness credits with a packing count.
// Does: adds one credit per request, removes one on every N-th
// forwarded accept, and saturates at the top of its range.
// Assumes: fwd_i is only raised while empty_o is low; pack_i == 0
// is treated as 1.
module trl_credit_pool #(
    parameter int unsigned CREDIT_W = 8,
    parameter int unsigned PACK_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                fwd_i,
    input  logic [PACK_W-1:0]   pack_i,
    output logic                empty_o,
    output logic [CREDIT_W-1:0] credits_o
);

    localparam logic [CREDIT_W-1:0] CRED_MAX = '1;

    logic [CREDIT_W-1:0] cred_q;
    logic [PACK_W-1:0]   pcnt_q;
    logic [PACK_W-1:0]   pack_last;
    logic                consume;

    // Last packing index; a factor of 0 behaves like 1.
    assign pack_last = (pack_i == '0) ? '0 : (pack_i - 1'b1);
    assign consume   = fwd_i && (pcnt_q >= pack_last);

    // Packing count: forwarded accepts since the last credit removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (consume) begin
            pcnt_q <= '0;
        end else if (fwd_i) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // Credit level: requests add, removals subtract, top saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cred_q <= '0;
        end else begin
            case ({req_i, consume})
                2'b10:   cred_q <= (cred_q == CRED_MAX) ? cred_q : cred_q + 1'b1;
                2'b01:   cred_q <= cred_q - 1'b1;
                default: cred_q <= cred_q;
            endcase
        end
    end

    assign empty_o   = (cred_q == '0);
    assign credits_o = cred_q;

endmodule

// File: rtl/trl_sat_cnt.sv
// Module: saturating event counter.
// Does: counts inc_i pulses and stops at all ones.
// Assumes: cleared only by the synchronous reset.
module trl_sat_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    // Count up until the ceiling is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/trl_rate_limiter.sv
// Module: trigger rate limiter (top).
// Does: filters the raw first-level accept. Throttle, empty credit
// pool and full buffer model each veto it, in that priority order.
// Each rejected accept is charged to one cause counter.
// Assumes: one clock (bunch crossing); synchronous active-low
// reset; throttle_async_i is asynchronous, the other inputs are
// synchronous.
module trl_rate_limiter #(
    parameter int unsigned BUF_DEPTH    = 16,
    parameter int unsigned DRAIN_CYCLES = 36,
    parameter int unsigned CREDIT_W     = 8,
    parameter int unsigned PACK_W       = 4,
    parameter int unsigned CNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l0_accept_i,
    input  logic              throttle_async_i,
    input  logic              credit_req_i,
    input  logic [PACK_W-1:0] pack_factor_i,
    output logic              accept_o,
    output logic [CNT_W-1:0]  rej_buf_cnt_o,
    output logic [CNT_W-1:0]  rej_thr_cnt_o,
    output logic [CNT_W-1:0]  rej_cred_cnt_o
);

    import trl_pkg::*;

    localparam int unsigned OCC_W = $clog2(BUF_DEPTH + 1);

    logic                thr_sync;
    logic                buf_full;
    logic                cred_empty;
    logic [OCC_W-1:0]    occ;
    logic [CREDIT_W-1:0] credits;
    veto_e               veto;
    logic                fwd;
    logic                accept_q;
    logic [N_CAUSES-1:0] hit;
    logic [CNT_W-1:0]    rej_cnt [N_CAUSES];

    trl_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (throttle_async_i),
        .q_o   (thr_sync)
    );

    trl_buf_model #(
        .DEPTH (BUF_DEPTH),
        .DRAIN (DRAIN_CYCLES)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (fwd),
        .full_o (buf_full),
        .occ_o  (occ)
    );

    trl_credit_pool #(
        .CREDIT_W (CREDIT_W),
        .PACK_W   (PACK_W)
    ) u_cred (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (credit_req_i),
        .fwd_i     (fwd),
        .pack_i    (pack_factor_i),
        .empty_o   (cred_empty),
        .credits_o (credits)
    );

    // Pick the highest-priority veto cause for this accept.
    always_comb begin
        if (!l0_accept_i) begin
            veto = VETO_NONE;
        end else if (thr_sync) begin
            veto = VETO_THR;
        end else if (cred_empty) begin
            veto = VETO_CRED;
        end else if (buf_full) begin
            veto = VETO_BUF;
        end else begin
            veto = VETO_NONE;
        end
    end

    assign fwd = l0_accept_i && (veto == VETO_NONE);

    // Register the filtered accept towards the front end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
        end else begin
            accept_q <= fwd;
        end
    end

    assign accept_o = accept_q;

    // Map the veto cause onto one counter strobe.
    always_comb begin
        hit           = '0;
        hit[IDX_BUF]  = (veto == VETO_BUF);
        hit[IDX_THR]  = (veto == VETO_THR);
        hit[IDX_CRED] = (veto == VETO_CRED);
    end

    for (genvar g = 0; g < N_CAUSES; g++) begin : g_rej
        trl_sat_cnt #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (hit[g]),
            .cnt_o (rej_cnt[g])
        );
    end

    assign rej_buf_cnt_o  = rej_cnt[IDX_BUF];
    assign rej_thr_cnt_o  = rej_cnt[IDX_THR];
    assign rej_cred_cnt_o = rej_cnt[IDX_CRED];

endmodule

// File: rtl/trl_rate_limiter_chk.sv
// Module: assertion checker for trl_rate_limiter, attached by bind.
// Assumes: it sees the top's ports, the synchronised throttle, the
// buffer occupancy and the credit level.
module trl_rate_limiter_chk #(
    parameter int unsigned BUF_DEPTH = 16,
    parameter int unsigned OCC_W     = 5,
    parameter int unsigned CREDIT_W  = 8,
    parameter int unsigned CNT_W     = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                l0_accept_i,
    input logic                accept_o,
    input logic                thr_sync,
    input logic [OCC_W-1:0]    occ,
    input logic [CREDIT_W-1:0] credits,
    input logic [CNT_W-1:0]    rej_buf_cnt_o,
    input logic [CNT_W-1:0]    rej_thr_cnt_o,
    input logic [CNT_W-1:0]    rej_cred_cnt_o
);

    assert_accept_needs_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(l0_accept_i));

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(BUF_DEPTH));

    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(BUF_DEPTH)) |=> !accept_o);

    assert_occ_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ + 1'b1 == $past(occ)));

    assert_throttle_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        thr_sync |=> !accept_o);

    assert_no_credit_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (credits == '0) |=> !accept_o);

    assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({rej_buf_cnt_o != $past(rej_buf_cnt_o),
                              rej_thr_cnt_o != $past(rej_thr_cnt_o),
                              rej_cred_cnt_o != $past(rej_cred_cnt_o)}) <= 1));

    assert_cnt_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rej_buf_cnt_o >= $past(rej_buf_cnt_o)) &&
                 (rej_thr_cnt_o >= $past(rej_thr_cnt_o)) &&
                 (rej_cred_cnt_o >= $past(rej_cred_cnt_o)));

endmodule

bind trl_rate_limiter trl_rate_limiter_chk #(
    .BUF_DEPTH (BUF_DEPTH),
    .OCC_W     (OCC_W),
    .CREDIT_W  (CREDIT_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .l0_accept_i    (l0_accept_i),
    .accept_o       (accept_o),
    .thr_sync       (thr_sync),
    .occ            (occ),
    .credits        (credits),
    .rej_buf_cnt_o  (rej_buf_cnt_o),
    .rej_thr_cnt_o  (rej_thr_cnt_o),
    .rej_cred_cnt_o (rej_cred_cnt_o)
);

// File: tb/trl_rate_limiter_test.sv
// Bench: scoreboard for trl_rate_limiter. The driver applies inputs
// at the falling edge and pushes the expected outputs, worked out
// from the requirements, into a queue. The monitor pops one entry
// just after each rising edge and compares.
module trl_rate_limiter_test;

    localparam int unsigned BUF_DEPTH    = 4;
    localparam int unsigned DRAIN_CYCLES = 6;
    localparam int unsigned CREDIT_W     = 3;
    localparam int unsigned PACK_W       = 3;
    localparam int unsigned CNT_W        = 4;
    localparam int          CRED_MAX     = (1 << CREDIT_W) - 1;
    localparam int          CNT_MAX      = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              l0_accept_i = 1'b0;
    logic              throttle_async_i = 1'b0;
    logic              credit_req_i = 1'b0;
    logic [PACK_W-1:0] pack_factor_i = '0;
    logic              accept_o;
    logic [CNT_W-1:0]  rej_buf_cnt_o;
    logic [CNT_W-1:0]  rej_thr_cnt_o;
    logic [CNT_W-1:0]  rej_cred_cnt_o;

    trl_rate_limiter #(
        .BUF_DEPTH    (BUF_DEPTH),
        .DRAIN_CYCLES (DRAIN_CYCLES),
        .CREDIT_W     (CREDIT_W),
        .PACK_W       (PACK_W),
        .CNT_W        (CNT_W)
    ) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .l0_accept_i      (l0_accept_i),
        .throttle_async_i (throttle_async_i),
        .credit_req_i     (credit_req_i),
        .pack_factor_i    (pack_factor_i),
        .accept_o         (accept_o),
        .rej_buf_cnt_o    (rej_buf_cnt_o),
        .rej_thr_cnt_o    (rej_thr_cnt_o),
        .rej_cred_cnt_o   (rej_cred_cnt_o)
    );

    // 50 MHz bench clock.
    always #10 clk = ~clk;

    typedef struct {
        bit    acc;
        int    cb;
        int    ct;
        int    cc;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Reference state, built from the requirements.
    int m_s1, m_s2, m_occ, m_dcnt, m_cred, m_pcnt, m_cb, m_ct, m_cc;

    task automatic model_reset();
        m_s1 = 0; m_s2 = 0; m_occ = 0; m_dcnt = 0;
        m_cred = 0; m_pcnt = 0; m_cb = 0; m_ct = 0; m_cc = 0;
    endtask

    task automatic check(string tag, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected result.
    task automatic step(bit a, bit thr, bit req, string tag);
        exp_t e;
        bit   fwd, drain, consume;
        int   nf;
        @(negedge clk);
        l0_accept_i      = a;
        throttle_async_i = thr;
        credit_req_i     = req;
        // R8: throttle outranks credits, credits outrank the buffer.
        fwd = 0;
        if (a) begin
            if (m_s2 != 0)                       m_ct = (m_ct == CNT_MAX) ? m_ct : m_ct + 1;
            else if (m_cred == 0)                m_cc = (m_cc == CNT_MAX) ? m_cc : m_cc + 1;
            else if (m_occ == int'(BUF_DEPTH))   m_cb = (m_cb == CNT_MAX) ? m_cb : m_cb + 1;
            else                                 fwd = 1;
        end
        e.acc = fwd; e.cb = m_cb; e.ct = m_ct; e.cc = m_cc; e.tag = tag;
        q.push_back(e);
        // R4: drain timer and occupancy.
        drain = (m_occ > 0) && (m_dcnt == int'(DRAIN_CYCLES) - 1);
        if (m_occ == 0 || drain) m_dcnt = 0; else m_dcnt++;
        m_occ = m_occ + int'(fwd) - int'(drain);
        // R6/R7: credit pool with packing.
        nf = (pack_factor_i == 0) ? 1 : int'(pack_factor_i);
        consume = fwd && (m_pcnt >= nf - 1);
        if (consume) m_pcnt = 0; else if (fwd) m_pcnt++;
        if (req && !consume)      m_cred = (m_cred == CRED_MAX) ? m_cred : m_cred + 1;
        else if (!req && consume) m_cred--;
        // R5: two synchroniser stages.
        m_s2 = m_s1;
        m_s1 = int'(thr);
    endtask

    // Monitor: compare just after each rising edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, int'(accept_o),       int'(e.acc), "accept_o");
            check(e.tag, int'(rej_buf_cnt_o),  e.cb,        "rej_buf_cnt_o");
            check(e.tag, int'(rej_thr_cnt_o),  e.ct,        "rej_thr_cnt_o");
            check(e.tag, int'(rej_cred_cnt_o), e.cc,        "rej_cred_cnt_o");
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired with %0d items pending", q.size());
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs during reset.
        check("R1", int'(accept_o), 0, "accept_o in reset");
        check("R1", int'(rej_buf_cnt_o) + int'(rej_thr_cnt_o) + int'(rej_cred_cnt_o), 0, "counters in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(accept_o), 0, "accept_o after reset");
        check("R1", int'(rej_cred_cnt_o), 0, "rej_cred_cnt_o after reset");

        // R6: an empty pool rejects every accept.
        pack_factor_i = 3'd1;
        repeat (3) step(1, 0, 0, "R6");
        repeat (2) step(0, 0, 1, "R6");
        repeat (3) step(1, 0, 0, "R6");
        repeat (20) step(0, 0, 0, "R4");

        // R6: request pulses saturate the pool.
        repeat (10) step(0, 0, 1, "R6");
        // R3: back-to-back accepts overfill the buffer model.
        pack_factor_i = 3'd4;
        repeat (12) step(1, 0, 0, "R3");
        repeat (30) step(0, 0, 0, "R4");

        // R4/R7: a steady accept stream paced by the drain, factor 0 counts as 1.
        pack_factor_i = 3'd0;
        repeat (5) step(0, 0, 1, "R7");
        repeat (40) step(1, 0, 0, "R4");
        repeat (30) step(0, 0, 0, "R4");

        // R7: request and removal on the same edge.
        pack_factor_i = 3'd2;
        repeat (3) step(0, 0, 1, "R7");
        repeat (12) step(1, 0, 1, "R7");
        repeat (30) step(0, 0, 0, "R4");

        // R5: throttle latency and release.
        repeat (7) step(0, 0, 1, "R5");
        step(1, 1, 0, "R5");
        step(1, 1, 0, "R5");
        step(1, 1, 0, "R5");
        step(1, 1, 0, "R5");
        step(1, 0, 0, "R5");
        step(1, 0, 0, "R5");
        step(1, 0, 0, "R5");
        repeat (30) step(0, 0, 0, "R4");

        // R8: all three causes active at once.
        pack_factor_i = 3'd1;
        repeat (2) step(0, 0, 1, "R8");
        repeat (6) step(1, 0, 0, "R8");
        repeat (4) step(1, 1, 0, "R8");
        repeat (3) step(1, 0, 0, "R8");

        // R9: push every counter past its ceiling.
        repeat (20) step(1, 1, 0, "R9");
        repeat (3) step(1, 0, 0, "R9");
        repeat (20) step(1, 0, 0, "R9");
        repeat (10) step(0, 0, 1, "R9");
        repeat (30) step(1, 0, 0, "R9");

        // R2: mixed pseudo-random traffic.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (i % 50 == 0) pack_factor_i = r[10:8];
            step(r[0] | r[1], (r[7:4] == 4'hF), r[2] & r[3], "R2");
        end
        repeat (4) step(0, 0, 0, "R2");

        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule